// File: doc/BRIEF.md
# Byte-Lane Set/Clear Control Register Bank

This block holds a small bank of 32-bit control registers that software changes with set/clear writes instead of read-modify-write sequences. Each write carries a 32-bit word and four byte strobes. In every byte lane whose strobe is high, the lane's top bit is the value to apply. The seven bits below it pick which stored bits take that value. Bits that are not picked keep their state, so two agents can change separate bits of one register without a lock.

Each register has its own fixed mask of implemented bits. The receive-demand bit and the four transmit-demand bits of the command register at address 0 act as one-cycle pulses and clear themselves. The write port is a single-cycle strobe that is always accepted, so it has no back-pressure. Reads are combinational from the read address. The full state of every register is also driven out as a flat vector for the logic that consumes the control bits.

Top module: `cmdreg_bank`

## Requirements
- R1: In each byte lane L (L = 0..3) whose strobe is high, bit 8L+7 is the value bit and bits 8L+6..8L select. Each selected implemented bit takes the value bit, and each unselected bit keeps its state. For example, writing 0x9A to lane 0 sets bits 1, 3 and 4, and writing 0x1A to lane 0 clears them.
- R2: A lane whose strobe bit wr_be[L] is low has no effect, whatever its data.
- R3: Bits outside a register's implemented mask, including the value-bit positions 7, 15, 23 and 31, always read as 0.
- R4: The address map and implemented masks are:
  - address 0: command register, mask 0x000F0F7F
  - address 1: mode register, mask 0x3F7F3F7F
  - address 2: wake register, mask 0x0000001B
  - address 3: interrupt-enable register, mask 0x1F7F7F1F

  A write changes only the addressed register.
- R5: A write with all four strobes high and data 0x7F7F7F7F clears every implemented bit of the addressed register.
- R6: While rst_n is low at a rising clock edge, every register is cleared to 0. Reset is synchronous and active low.
- R7: In the register at address 0, bits 11:8 are transmit demands for rings 3..0 and bit 16 is the receive demand. A demand bit that a write sets is 1 for exactly the one cycle after that write edge, on tx_demand[k] (which is bit 8+k) or on rx_demand, and in the register state. It then clears unless it is set again.
- R8: rd_data shows register rd_addr combinationally. ctrl_flat[32k+31:32k] shows register k.
- R9: With wr_en low, no register changes apart from the clearing of demand bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 2 | Register selected for the write |
| wr_data | input | 32 | Per-lane value bit and select mask |
| wr_be | input | 4 | Byte-lane strobes |
| rd_addr | input | 2 | Register selected for reading |
| rd_data | output | 32 | Current state of register rd_addr |
| ctrl_flat | output | 128 | State of all registers, register k in bits 32k+31:32k |
| tx_demand | output | 4 | Transmit-demand pulses for rings 3..0 |
| rx_demand | output | 1 | Receive-demand pulse |

## Verification
Directed writes of 0x9A and 0x1A to lane 0 separate a true set/clear from plain storage of the data byte. All-ones data shows that unimplemented and value-bit positions stay 0. Data under a low strobe shows that the strobe gates its lane. The all-clear pattern, writes to a neighbouring address, and a single demand write followed by idle cycles isolate reset of the implemented bits, address decode and the one-cycle pulse width. Random address, data and strobe mixes then expose any cross-lane leakage or pulse bit that sticks, because each result is compared with a bench model built from the requirements.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;
  localparam int WORD_W  = 32;
  localparam int LANE_W  = 8;
  localparam int N_LANES = WORD_W / LANE_W;

  // Implemented-bit mask per register index
  function automatic logic [WORD_W-1:0] impl_mask(input int idx);
    case (idx)
      0:       return 32'h000F_0F7F;
      1:       return 32'h3F7F_3F7F;
      2:       return 32'h0000_001B;
      3:       return 32'h1F7F_7F1F;
      default: return '0;
    endcase
  endfunction

  // Self-clearing demand bits per register index
  function automatic logic [WORD_W-1:0] pulse_mask(input int idx);
    return (idx == 0) ? 32'h0001_0F00 : '0;
  endfunction

  localparam int TXD_LSB = 8;
  localparam int TXD_N   = 4;
  localparam int RXD_BIT = 16;
endpackage

// File: rtl/cmdreg_lane_decode.sv
module cmdreg_lane_decode
  import cmdreg_pkg::*;
(
  input  logic [WORD_W-1:0]  data,
  input  logic [N_LANES-1:0] be,
  output logic [WORD_W-1:0]  sel,
  output logic [WORD_W-1:0]  val
);
  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    assign sel[l*LANE_W +: LANE_W] =
      be[l] ? {1'b0, data[l*LANE_W +: LANE_W-1]} : '0;
    assign val[l*LANE_W +: LANE_W] = {LANE_W{data[l*LANE_W + LANE_W-1]}};
  end
endmodule

// File: rtl/cmdreg_cell.sv
module cmdreg_cell
  import cmdreg_pkg::*;
#(
  parameter logic [WORD_W-1:0] IMPL  = '1,
  parameter logic [WORD_W-1:0] PULSE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic [WORD_W-1:0] sel,
  input  logic [WORD_W-1:0] val,
  output logic [WORD_W-1:0] q
);
  logic [WORD_W-1:0] q_r, keep, nxt;

  // demand bits never survive a cycle on their own
  assign keep = q_r & ~PULSE;

  always_comb begin
    if (hit) nxt = IMPL & ((sel & val) | (~sel & keep));
    else     nxt = IMPL & keep;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= nxt;
  end

  assign q = q_r;
endmodule

// File: rtl/cmdreg_rdmux.sv
module cmdreg_rdmux
  import cmdreg_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int ADDR_W   = 2
) (
  input  logic [NUM_REGS*WORD_W-1:0] flat,
  input  logic [ADDR_W-1:0]          addr,
  output logic [WORD_W-1:0]          data
);
  always_comb begin
    data = '0;
    for (int k = 0; k < NUM_REGS; k++)
      if (addr == ADDR_W'(k)) data = flat[k*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/cmdreg_bank.sv
module cmdreg_bank
  import cmdreg_pkg::*;
#(
  parameter int NUM_REGS = 4,
  localparam int ADDR_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [WORD_W-1:0]          wr_data,
  input  logic [N_LANES-1:0]         wr_be,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [WORD_W-1:0]          rd_data,
  output logic [NUM_REGS*WORD_W-1:0] ctrl_flat,
  output logic [TXD_N-1:0]           tx_demand,
  output logic                       rx_demand
);
  logic [WORD_W-1:0] sel, val;

  cmdreg_lane_decode u_dec (
    .data (wr_data),
    .be   (wr_be),
    .sel  (sel),
    .val  (val)
  );

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_addr == ADDR_W'(k));
    cmdreg_cell #(
      .IMPL  (impl_mask(k)),
      .PULSE (pulse_mask(k))
    ) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (hit),
      .sel   (sel),
      .val   (val),
      .q     (ctrl_flat[k*WORD_W +: WORD_W])
    );
  end

  cmdreg_rdmux #(
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W)
  ) u_rd (
    .flat (ctrl_flat),
    .addr (rd_addr),
    .data (rd_data)
  );

  assign tx_demand = ctrl_flat[TXD_LSB +: TXD_N];
  assign rx_demand = ctrl_flat[RXD_BIT];
endmodule

// File: rtl/cmdreg_bank_chk.sv
module cmdreg_bank_chk
  import cmdreg_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int ADDR_W   = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_en,
  input logic [ADDR_W-1:0]          wr_addr,
  input logic [WORD_W-1:0]          wr_data,
  input logic [N_LANES-1:0]         wr_be,
  input logic [NUM_REGS*WORD_W-1:0] ctrl_flat,
  input logic [TXD_N-1:0]           tx_demand,
  input logic                       rx_demand
);
  localparam logic [NUM_REGS*WORD_W-1:0] VALPOS = {NUM_REGS{32'h8080_8080}};

  function automatic logic [NUM_REGS*WORD_W-1:0] all_pulse();
    logic [NUM_REGS*WORD_W-1:0] m;
    m = '0;
    for (int k = 0; k < NUM_REGS; k++) m[k*WORD_W +: WORD_W] = pulse_mask(k);
    return m;
  endfunction
  localparam logic [NUM_REGS*WORD_W-1:0] PFLAT = all_pulse();

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> ctrl_flat == '0); // R6

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ctrl_flat == ($past(ctrl_flat) & ~PFLAT)); // R9

  AST_STROBE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be == '0) |=> ctrl_flat == ($past(ctrl_flat) & ~PFLAT)); // R2

  AST_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_demand != '0 || rx_demand) && !wr_en) |=> (tx_demand == '0 && !rx_demand)); // R7

  AST_SET_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == '0 && wr_be[0] && wr_data[7] && wr_data[0]) |=> ctrl_flat[0]); // R1

  AST_VALPOS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_flat & VALPOS) == '0); // R3
endmodule

bind cmdreg_bank cmdreg_bank_chk #(
  .NUM_REGS (NUM_REGS),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .wr_be     (wr_be),
  .ctrl_flat (ctrl_flat),
  .tx_demand (tx_demand),
  .rx_demand (rx_demand)
);

// File: tb/sim_cmdreg_bank.sv
`timescale 1ns/100ps
module sim_cmdreg_bank;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = '0;
  logic [31:0]  wr_data = '0;
  logic [3:0]   wr_be = '0;
  logic [1:0]   rd_addr = '0;
  logic [31:0]  rd_data;
  logic [127:0] ctrl_flat;
  logic [3:0]   tx_demand;
  logic         rx_demand;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] mdl [4];

  always #2.5 clk = ~clk;

  cmdreg_bank u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be), .rd_addr(rd_addr), .rd_data(rd_data),
    .ctrl_flat(ctrl_flat), .tx_demand(tx_demand), .rx_demand(rx_demand)
  );

  // masks from R4, demand positions from R7
  function automatic logic [31:0] b_impl(input int k);
    case (k)
      0: return 32'h000F0F7F;
      1: return 32'h3F7F3F7F;
      2: return 32'h0000001B;
      default: return 32'h1F7F7F1F;
    endcase
  endfunction

  function automatic logic [31:0] b_pulse(input int k);
    return (k == 0) ? 32'h00010F00 : 32'h0;
  endfunction

  // R1/R2: per-bit set/clear rule
  function automatic logic [31:0] b_apply(input logic [31:0] cur, input logic [31:0] d,
                                          input logic [3:0] be, input int k);
    logic [31:0] r;
    r = cur;
    for (int l = 0; l < 4; l++)
      if (be[l])
        for (int b = 0; b < 7; b++)
          if (d[l*8+b]) r[l*8+b] = d[l*8+7];
    return r & b_impl(k);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_idle();
    for (int k = 0; k < 4; k++) mdl[k] = mdl[k] & ~b_pulse(k);
  endtask

  task automatic compare(input string req);
    for (int k = 0; k < 4; k++)
      check(ctrl_flat[k*32 +: 32] === mdl[k], req, ctrl_flat[k*32 +: 32], mdl[k]);
    check(tx_demand === mdl[0][11:8], "R7", {28'h0, tx_demand}, {28'h0, mdl[0][11:8]});
    check(rx_demand === mdl[0][16], "R7", {31'h0, rx_demand}, {31'h0, mdl[0][16]});
  endtask

  task automatic rd_check(input int k);
    rd_addr = 2'(k);
    #1;
    check(rd_data === mdl[k], "R8", rd_data, mdl[k]);
  endtask

  task automatic wr(input int k, input logic [31:0] d, input logic [3:0] be,
                    input string req);
    model_idle();
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'(k); wr_data = d; wr_be = be;
    @(negedge clk);
    wr_en = 1'b0; wr_data = $urandom; wr_be = 4'($urandom);
    model_idle();
    mdl[k] = b_apply(mdl[k], d, be, k);
    compare(req);
    rd_check(k);
  endtask

  task automatic idle(input string req);
    @(negedge clk);
    model_idle();
    compare(req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    for (int k = 0; k < 4; k++) mdl[k] = '0;
    compare("R6");
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    finish_run();
  end

  initial begin
    void'($urandom(32'd7741));
    for (int k = 0; k < 4; k++) mdl[k] = '0;
    do_reset();

    // R1: set and clear bits 1,3,4 through lane 0
    wr(0, 32'h0000009A, 4'b0001, "R1");
    check(ctrl_flat[31:0] === 32'h1A, "R1", ctrl_flat[31:0], 32'h1A);
    wr(0, 32'h0000001A, 4'b0001, "R1");
    check(ctrl_flat[31:0] === 32'h0, "R1", ctrl_flat[31:0], 32'h0);

    // R2: data on disabled lanes is ignored
    wr(3, 32'hFFFFFFFF, 4'b0000, "R2");
    check(ctrl_flat[127:96] === 32'h0, "R2", ctrl_flat[127:96], 32'h0);
    wr(3, 32'hFFFFFFFF, 4'b0100, "R2");
    check(ctrl_flat[127:96] === 32'h007F0000, "R2", ctrl_flat[127:96], 32'h007F0000);

    // R3/R4: all-ones shows the implemented mask of each address
    for (int k = 0; k < 4; k++) begin
      wr(k, 32'hFFFFFFFF, 4'hF, "R3");
      check(ctrl_flat[k*32 +: 32] === (b_impl(k) & ~b_pulse(k)) || k == 0, "R4",
            ctrl_flat[k*32 +: 32], b_impl(k));
    end
    idle("R7");

    // R4: writes to one address leave the others alone
    wr(1, 32'h7F7F7F7F, 4'hF, "R4");
    check(ctrl_flat[127:64] === {b_impl(3), b_impl(2)}, "R4",
          ctrl_flat[95:64], b_impl(2));

    // R5: clear-all pattern
    wr(3, 32'h7F7F7F7F, 4'hF, "R5");
    check(ctrl_flat[127:96] === 32'h0, "R5", ctrl_flat[127:96], 32'h0);

    // R7: demand pulses last one cycle
    wr(0, 32'h00818A00, 4'b0110, "R7");
    check(tx_demand === 4'hA && rx_demand === 1'b1, "R7",
          {27'h0, rx_demand, tx_demand}, 32'h1A);
    idle("R7");
    check(tx_demand === 4'h0 && rx_demand === 1'b0, "R7",
          {27'h0, rx_demand, tx_demand}, 32'h0);

    // R9: idle cycles keep stored bits
    wr(2, 32'h0000009B, 4'b0001, "R9");
    idle("R9");
    idle("R9");

    // random mix
    for (int i = 0; i < 400; i++) begin
      int k;
      logic [31:0] d;
      k = int'($urandom_range(0, 3));
      d = $urandom;
      wr(k, d, 4'($urandom), "R1/R2/R3");
      if ($urandom_range(0, 3) == 0) idle("R7/R9");
    end

    // R6: reset in the middle of a run
    wr(3, 32'hFFFFFFFF, 4'hF, "R6");
    do_reset();
    idle("R6");

    finish_run();
  end
endmodule